// File: doc/BRIEF.md
# FM0 Return-Link Decoder with Preamble Period Filter

This block takes one digitised envelope channel carrying a tag's FM0 bi-phase reply and turns it into a stored bit string. The raw line is synchronised and passed through a majority-free stability filter, so a pulse that lasts a single system clock never reaches the edge detector. While it hunts for a preamble, the block measures every interval between edges. An interval that falls outside a programmable window around the expected bit period throws away the partial measurement. A run of accepted full-period intervals is averaged to give the measured bit period, which then times the decoding of the data bits (autobaud).

In FM0 every bit starts with a transition. A second transition inside the bit marks a ZERO; its absence marks a ONE. Each closed bit is shifted into a result register, and the open bit left when the line goes quiet is the terminating dummy ONE, which is never stored. The frame result is held on the outputs until the next accepted preamble: a done flag, a bit-error flag, a length-overflow flag and the bit count. Free-running saturating counters report filtered edges and preamble rejections. The block ignores the line while the local transmitter is active. Hosts set the expected period, the tolerance width and the expected data length through plain input ports.

Top module: `fm0_rx_decoder`

## Requirements
- R1: A pulse on `rxIn` lasting one system clock is removed: it is not counted as an edge and does not disturb the decoding of the surrounding frame.
- R2: With `ePer` nonzero, a preamble interval is accepted only if it lies within `ePer - d` to `ePer + d` inclusive. Here `d = ePer>>2` when `tolWide` is 0 and `d = ePer>>1` when it is 1. A reply whose intervals all exceed the window leaves `bitCnt`, `dataOut`, the flags and `preErrCnt` unchanged.
- R3: During the preamble hunt, an interval shorter than the window adds one to `preErrCnt` and restarts the measurement, with that edge as the first preamble edge. A following clean preamble is then decoded.
- R4: With `ePer` = 0 the window is fixed to the range of 32 kHz to 640 kHz bit rates: `CLK_HZ/640000` to `CLK_HZ/32000` clocks inclusive. This is 31 to 625 clocks at the default `CLK_HZ`.
- R5: The preamble is one starting edge followed by `PRE_LEN` (default 4, a power of two) accepted intervals. `measPer` becomes their mean, in clocks.
- R6: After the preamble, a bit with a transition before 3/4 of `measPer` decodes as 0, and a bit without one decodes as 1. The first data bit ends at position `bitCnt-1` of `dataOut` and the last at position 0. Higher positions are zero.
- R7: When no boundary transition follows within 1.5 `measPer`, the open bit is the dummy. If it has no mid transition and `bitCnt` equals `expLen`, `frameDone` is set and the dummy is not stored.
- R8: A silence end with `bitCnt` different from `expLen`, a silence end where the open bit had a mid transition, or a second mid transition in one bit sets `bitErr` instead of `frameDone`.
- R9: A data bit that would exceed `MAX_BITS` (552) sets `lenOvf` and ends the frame, with `bitCnt` equal to `MAX_BITS` and the first 552 bits kept.
- R10: While `txActive` is high, activity on `rxIn` changes no output, and any frame in progress is abandoned.
- R11: `edgeCnt` counts every filtered edge seen while `txActive` is low, and it holds at 16'hFFFF once it gets there.
- R12: `preErrCnt` holds at 8'hFF once it gets there.
- R13: After reset every output is zero. Each accepted preamble clears `dataOut`, `bitCnt` and the three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Digitised envelope channel from the receiver |
| txActive | input | 1 | High while the local transmitter is active; the line is ignored |
| ePer | input | 14 | Expected bit period in clocks, 0 disables the programmable window |
| tolWide | input | 1 | Window tolerance: 0 = ±25 %, 1 = ±50 % |
| expLen | input | 10 | Expected number of data bits, dummy excluded |
| dataOut | output | 552 | Decoded bits, last received bit at position 0 |
| bitCnt | output | 10 | Number of stored data bits |
| measPer | output | 16 | Bit period measured from the preamble, in clocks |
| frameDone | output | 1 | Frame ended normally |
| bitErr | output | 1 | Frame ended on a coding or length error |
| lenOvf | output | 1 | Frame exceeded the data capacity |
| edgeCnt | output | 16 | Saturating count of filtered edges |
| preErrCnt | output | 8 | Saturating count of preamble rejections |

## Verification
The checker watches several properties on every cycle. Nothing moves while the transmitter is active. Both counters stay pinned once saturated. The bit count only steps by one or returns to zero, and it never passes the capacity. An overflow always comes with a full count, and the three end flags never appear together. The bench scenarios cover what needs a whole reply to show. These are the window edges at both tolerances, the rejection and restart of a corrupted preamble, and autobaud at the slowest and fastest rates. They also include the discarded dummy bit, glitch removal inside a live frame, the error endings and the 553-bit overflow.

// File: rtl/fm0_rx_pkg.sv
package fm0_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rxState_e;

  // strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic clrFrame;
    logic shiftEn;
    logic shiftBit;
    logic setDone;
    logic setBitErr;
    logic setOvf;
    logic preErr;
  } rxStrobe_t;

endpackage

// File: rtl/fm0_rx_glitch_filter.sv
module fm0_rx_glitch_filter #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxIn,
  input  logic txActive,
  output logic edgeOut
);

  logic [1:0] syncQ;
  logic       rxClean;
  logic       rxCleanD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      rxCleanD <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], rxIn};
      rxCleanD <= rxClean;
    end
  end

  generate
    if (FILT_LEN > 1) begin : g_vote
      logic [FILT_LEN-1:0] hist;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          hist    <= '0;
          rxClean <= 1'b0;
        end else begin
          hist <= {hist[FILT_LEN-2:0], syncQ[1]};
          if (&hist)
            rxClean <= 1'b1;
          else if (~|hist)
            rxClean <= 1'b0;
        end
      end
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (!rstN) rxClean <= 1'b0;
        else       rxClean <= syncQ[1];
      end
    end
  endgenerate

  // level keeps tracking during transmit so no stale edge appears afterwards
  assign edgeOut = (rxClean ^ rxCleanD) & ~txActive;

endmodule

// File: rtl/fm0_rx_ctrl.sv
module fm0_rx_ctrl
  import fm0_rx_pkg::*;
#(
  parameter int TW       = 16,
  parameter int EPW      = 14,
  parameter int CW       = 10,
  parameter int PRE_LEN  = 4,
  parameter int MAX_BITS = 552,
  parameter int MIN_PER  = 31,
  parameter int MAX_PER  = 625
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           edgeIn,
  input  logic           txActive,
  input  logic [EPW-1:0] ePer,
  input  logic           tolWide,
  input  logic [CW-1:0]  expLen,
  input  logic [CW-1:0]  bitCnt,
  output rxStrobe_t      stb,
  output logic [TW-1:0]  measPer
);

  localparam int PLOG = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 0;
  localparam int SW   = TW + PLOG + 1;
  localparam logic [PLOG:0]  LAST_ACC = (PLOG+1)'(PRE_LEN - 1);
  localparam logic [CW-1:0]  CAP      = CW'(MAX_BITS);
  localparam logic [TW-1:0]  TMAX     = '1;

  rxState_e       state, stateN;
  logic [TW-1:0]  tmr, tmrN;
  logic [PLOG:0]  nAcc, nAccN;
  logic [SW-1:0]  sum, sumN;
  logic [TW-1:0]  per, perN;
  logic           midSeen, midN;

  // acceptance window for preamble intervals
  logic [TW-1:0] ePerW, dev, winLo, winHi;
  logic          inWin;
  always_comb begin
    ePerW = TW'(ePer);
    dev   = tolWide ? (ePerW >> 1) : (ePerW >> 2);
    if (ePer == '0) begin
      winLo = TW'(MIN_PER);
      winHi = TW'(MAX_PER);
    end else begin
      winLo = ePerW - dev;
      winHi = ePerW + dev;
    end
    inWin = (tmr >= winLo) && (tmr <= winHi);
  end

  // decision thresholds derived from the measured period
  logic [TW-1:0] q3;
  logic [TW:0]   h3;
  assign q3 = per - (per >> 2);
  assign h3 = {1'b0, per} + ({1'b0, per} >> 1);

  always_comb begin
    stb    = '0;
    stateN = state;
    tmrN   = (tmr == TMAX) ? tmr : tmr + 1'b1;
    nAccN  = nAcc;
    sumN   = sum;
    perN   = per;
    midN   = midSeen;
    if (txActive) begin
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (edgeIn) begin
            stateN = ST_HUNT;
            tmrN   = TW'(1);
            nAccN  = '0;
            sumN   = '0;
          end
        end
        ST_HUNT: begin
          if (edgeIn) begin
            tmrN = TW'(1);
            if (inWin) begin
              if (nAcc == LAST_ACC) begin
                stateN       = ST_DATA;
                perN         = TW'((sum + SW'(tmr)) >> PLOG);
                midN         = 1'b0;
                stb.clrFrame = 1'b1;
              end else begin
                nAccN = nAcc + 1'b1;
                sumN  = sum + SW'(tmr);
              end
            end else begin
              stb.preErr = 1'b1;
              nAccN      = '0;
              sumN       = '0;
            end
          end else if (tmr > winHi) begin
            stateN     = ST_IDLE;
            stb.preErr = (nAcc != '0);
          end
        end
        ST_DATA: begin
          if (edgeIn) begin
            if (tmr < q3) begin
              if (midSeen) begin
                stb.setBitErr = 1'b1;
                stateN        = ST_IDLE;
              end else begin
                midN = 1'b1;
              end
            end else begin
              tmrN = TW'(1);
              midN = 1'b0;
              if (bitCnt == CAP) begin
                stb.setOvf = 1'b1;
                stateN     = ST_IDLE;
              end else begin
                stb.shiftEn  = 1'b1;
                stb.shiftBit = ~midSeen;
              end
            end
          end else if ({1'b0, tmr} > h3) begin
            stateN = ST_IDLE;
            if (!midSeen && (bitCnt == expLen))
              stb.setDone = 1'b1;
            else
              stb.setBitErr = 1'b1;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      nAcc    <= '0;
      sum     <= '0;
      per     <= '0;
      midSeen <= 1'b0;
    end else begin
      state   <= stateN;
      tmr     <= tmrN;
      nAcc    <= nAccN;
      sum     <= sumN;
      per     <= perN;
      midSeen <= midN;
    end
  end

  assign measPer = per;

endmodule

// File: rtl/fm0_rx_datapath.sv
module fm0_rx_datapath
  import fm0_rx_pkg::*;
#(
  parameter int MAX_BITS = 552,
  parameter int CW       = 10,
  parameter int ECW      = 16,
  parameter int PCW      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           stb,
  input  logic                edgeIn,
  output logic [MAX_BITS-1:0] dataOut,
  output logic [CW-1:0]       bitCnt,
  output logic                frameDone,
  output logic                bitErr,
  output logic                lenOvf,
  output logic [ECW-1:0]      edgeCnt,
  output logic [PCW-1:0]      preErrCnt
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      bitCnt    <= '0;
      frameDone <= 1'b0;
      bitErr    <= 1'b0;
      lenOvf    <= 1'b0;
    end else if (stb.clrFrame) begin
      dataOut   <= '0;
      bitCnt    <= '0;
      frameDone <= 1'b0;
      bitErr    <= 1'b0;
      lenOvf    <= 1'b0;
    end else begin
      if (stb.shiftEn) begin
        dataOut <= {dataOut[MAX_BITS-2:0], stb.shiftBit};
        bitCnt  <= bitCnt + 1'b1;
      end
      if (stb.setDone)   frameDone <= 1'b1;
      if (stb.setBitErr) bitErr    <= 1'b1;
      if (stb.setOvf)    lenOvf    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt   <= '0;
      preErrCnt <= '0;
    end else begin
      if (edgeIn && (edgeCnt != '1))
        edgeCnt <= edgeCnt + 1'b1;
      if (stb.preErr && (preErrCnt != '1))
        preErrCnt <= preErrCnt + 1'b1;
    end
  end

endmodule

// File: rtl/fm0_rx_decoder.sv
module fm0_rx_decoder
  import fm0_rx_pkg::*;
#(
  parameter int MAX_BITS = 552,
  parameter int CLK_HZ   = 20_000_000,
  parameter int EPW      = 14,
  parameter int TW       = 16,
  parameter int PRE_LEN  = 4,
  parameter int FILT_LEN = 2,
  parameter int ECW      = 16,
  parameter int PCW      = 8,
  localparam int CW      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic                txActive,
  input  logic [EPW-1:0]      ePer,
  input  logic                tolWide,
  input  logic [CW-1:0]       expLen,
  output logic [MAX_BITS-1:0] dataOut,
  output logic [CW-1:0]       bitCnt,
  output logic [TW-1:0]       measPer,
  output logic                frameDone,
  output logic                bitErr,
  output logic                lenOvf,
  output logic [ECW-1:0]      edgeCnt,
  output logic [PCW-1:0]      preErrCnt
);

  localparam int MIN_PER = CLK_HZ / 640_000;
  localparam int MAX_PER = CLK_HZ / 32_000;

  logic      edgeSeen;
  rxStrobe_t stb;

  fm0_rx_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .txActive (txActive),
    .edgeOut  (edgeSeen)
  );

  fm0_rx_ctrl #(
    .TW(TW), .EPW(EPW), .CW(CW), .PRE_LEN(PRE_LEN),
    .MAX_BITS(MAX_BITS), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeIn   (edgeSeen),
    .txActive (txActive),
    .ePer     (ePer),
    .tolWide  (tolWide),
    .expLen   (expLen),
    .bitCnt   (bitCnt),
    .stb      (stb),
    .measPer  (measPer)
  );

  fm0_rx_datapath #(
    .MAX_BITS(MAX_BITS), .CW(CW), .ECW(ECW), .PCW(PCW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .edgeIn    (edgeSeen),
    .dataOut   (dataOut),
    .bitCnt    (bitCnt),
    .frameDone (frameDone),
    .bitErr    (bitErr),
    .lenOvf    (lenOvf),
    .edgeCnt   (edgeCnt),
    .preErrCnt (preErrCnt)
  );

endmodule

// File: rtl/fm0_rx_checker.sv
module fm0_rx_checker #(
  parameter int MAX_BITS = 552,
  parameter int CW       = 10,
  parameter int ECW      = 16,
  parameter int PCW      = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           txActive,
  input logic [CW-1:0]  bitCnt,
  input logic           frameDone,
  input logic           bitErr,
  input logic           lenOvf,
  input logic [ECW-1:0] edgeCnt,
  input logic [PCW-1:0] preErrCnt
);

  // R10
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    txActive |=> ($stable(edgeCnt) && $stable(bitCnt) && $stable(preErrCnt)
                  && $stable(frameDone) && $stable(bitErr) && $stable(lenOvf)));

  // R11
  edge_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == '1) |=> (edgeCnt == '1));

  // R12
  pre_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preErrCnt == '1) |=> (preErrCnt == '1));

  // R9
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    lenOvf |-> (bitCnt == CW'(MAX_BITS)));

  // R9
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CW'(MAX_BITS));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != $past(bitCnt)) |-> ((bitCnt == $past(bitCnt) + 1'b1) || (bitCnt == '0)));

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({frameDone, bitErr, lenOvf}) <= 1);

endmodule

bind fm0_rx_decoder fm0_rx_checker #(
  .MAX_BITS(MAX_BITS), .CW(CW), .ECW(ECW), .PCW(PCW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txActive  (txActive),
  .bitCnt    (bitCnt),
  .frameDone (frameDone),
  .bitErr    (bitErr),
  .lenOvf    (lenOvf),
  .edgeCnt   (edgeCnt),
  .preErrCnt (preErrCnt)
);

// File: tb/sim_fm0_rx_decoder.sv
module sim_fm0_rx_decoder;
  localparam int MAXB = 552;
  localparam int PRE  = 4;

  logic clk = 1'b0, rstN = 1'b0, rxIn = 1'b0, txActive = 1'b0, tolWide = 1'b0;
  logic [13:0]     ePer = '0;
  logic [9:0]      expLen = '0;
  logic [MAXB-1:0] dataOut;
  logic [9:0]      bitCnt;
  logic [15:0]     measPer;
  logic            frameDone, bitErr, lenOvf;
  logic [15:0]     edgeCnt;
  logic [7:0]      preErrCnt;

  always #10 clk = ~clk;

  fm0_rx_decoder u0 (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .txActive(txActive), .ePer(ePer),
    .tolWide(tolWide), .expLen(expLen), .dataOut(dataOut), .bitCnt(bitCnt),
    .measPer(measPer), .frameDone(frameDone), .bitErr(bitErr), .lenOvf(lenOvf),
    .edgeCnt(edgeCnt), .preErrCnt(preErrCnt)
  );

  int checks = 0, errors = 0, expEdges = 0, expCnt = 0;
  bit finished = 1'b0;
  logic [MAXB-1:0] expData;
  bit txBits [0:599];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog();
    rxIn = ~rxIn;
    if (!txActive) expEdges++;
  endtask

  // FM0 reply: start edge, PRE full-period intervals, data, dummy, silence
  task automatic sendFrame(input int per, input int n, input bit lastOne,
                           input bit glitch, input bit fault);
    tog();
    if (fault) begin
      w(per); tog(); w(20); tog();
    end
    for (int i = 0; i < PRE; i++) begin w(per); tog(); end
    for (int i = 0; i < n; i++) begin
      if (txBits[i]) begin
        if (glitch && i == 0) begin
          w(per/2); rxIn = ~rxIn; w(1); rxIn = ~rxIn; w(per - per/2 - 1);
        end else begin
          w(per);
        end
        tog();
      end else begin
        w(per/2); tog(); w(per/2); tog();
      end
    end
    if (lastOne) w(per);
    else begin w(per/2); tog(); w(per/2); end
    w(2*per + 12);
  endtask

  task automatic model(input int n);
    expData = '0;
    expCnt  = 0;
    for (int i = 0; i < n; i++) begin
      if (expCnt < MAXB) begin
        expData = {expData[MAXB-2:0], txBits[i]};
        expCnt++;
      end
    end
  endtask

  task automatic checkGood(input string tag, input int per);
    chk(frameDone == 1'b1, tag, "frameDone", frameDone, 1);
    chk(bitErr == 1'b0 && lenOvf == 1'b0, tag, "error flags", {bitErr, lenOvf}, 0);
    chk(int'(bitCnt) == expCnt, tag, "bitCnt", bitCnt, expCnt);
    chk(dataOut == expData, tag, "dataOut low word", dataOut[63:0], expData[63:0]);
    chk(int'(measPer) == per, "R5", "measPer", measPer, per);
    chk(int'(edgeCnt) == expEdges, "R11", "edgeCnt", edgeCnt, expEdges);
  endtask

  task automatic fillBits(input int n, input logic [31:0] pat);
    for (int i = 0; i < n; i++) txBits[i] = pat[n-1-i];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedInit;
    int savedCnt, savedErr;
    logic savedDone;
    seedInit = $urandom(32'd51873);
    w(5);
    rstN = 1'b1;
    w(3);
    // R13 reset state
    chk(dataOut == '0 && bitCnt == '0 && measPer == '0, "R13", "data/count/period", bitCnt, 0);
    chk({frameDone, bitErr, lenOvf} == 3'b0 && edgeCnt == '0 && preErrCnt == '0,
        "R13", "flags/counters", edgeCnt, 0);

    // R6 R7 R4: basic decode with autobaud, fast rate
    ePer = '0; tolWide = 1'b0;
    fillBits(8, 32'hB2); expLen = 10'd8; model(8);
    sendFrame(40, 8, 1'b1, 1'b0, 1'b0);
    checkGood("R6", 40);

    // R4 slowest accepted rate limit and fastest limit
    fillBits(2, 32'h1); expLen = 10'd2; model(2);
    sendFrame(624, 2, 1'b1, 1'b0, 1'b0);
    checkGood("R4", 624);
    fillBits(5, 32'h0D); expLen = 10'd5; model(5);
    sendFrame(32, 5, 1'b1, 1'b0, 1'b0);
    checkGood("R4", 32);

    // R1 glitch inside the first data bit
    fillBits(6, 32'h2D); expLen = 10'd6; model(6);
    sendFrame(60, 6, 1'b1, 1'b1, 1'b0);
    checkGood("R1", 60);

    // R2 window rejects 90 at 64 +/-25 %
    ePer = 14'd64; tolWide = 1'b0;
    savedCnt = int'(bitCnt); savedDone = frameDone; savedErr = int'(preErrCnt);
    fillBits(5, 32'h1F); expLen = 10'd5;
    sendFrame(90, 5, 1'b1, 1'b0, 1'b0);
    chk(int'(bitCnt) == savedCnt && dataOut == expData, "R2", "bitCnt kept", bitCnt, savedCnt);
    chk(frameDone == savedDone && int'(preErrCnt) == savedErr, "R2", "preErrCnt kept",
        preErrCnt, savedErr);
    // R2 wide tolerance accepts 90
    tolWide = 1'b1; model(5);
    sendFrame(90, 5, 1'b1, 1'b0, 1'b0);
    checkGood("R2", 90);
    // R2 inclusive edges of the narrow window: 80 and 48
    tolWide = 1'b0;
    fillBits(7, 32'h4B); expLen = 10'd7; model(7);
    sendFrame(80, 7, 1'b1, 1'b0, 1'b0);
    checkGood("R2", 80);
    sendFrame(48, 7, 1'b1, 1'b0, 1'b0);
    checkGood("R2", 48);

    // R3 short interval restarts the preamble
    savedErr = int'(preErrCnt);
    fillBits(4, 32'h6); expLen = 10'd4; model(4);
    sendFrame(64, 4, 1'b1, 1'b0, 1'b1);
    chk(int'(preErrCnt) == savedErr + 1, "R3", "preErrCnt", preErrCnt, savedErr + 1);
    checkGood("R3", 64);

    // R8 too few data bits
    ePer = '0;
    fillBits(5, 32'h13); expLen = 10'd7; model(5);
    sendFrame(50, 5, 1'b1, 1'b0, 1'b0);
    chk(bitErr == 1'b1 && frameDone == 1'b0, "R8", "short frame bitErr", bitErr, 1);
    chk(int'(bitCnt) == 5, "R8", "short frame bitCnt", bitCnt, 5);
    // R8 terminating bit carries a mid transition
    expLen = 10'd5;
    sendFrame(50, 5, 1'b0, 1'b0, 1'b0);
    chk(bitErr == 1'b1 && frameDone == 1'b0, "R8", "zero dummy bitErr", bitErr, 1);

    // R9 overflow with 553 data bits
    for (int i = 0; i < 553; i++) txBits[i] = ((i * 7 + 3) % 5) < 2;
    expLen = 10'd552; model(553);
    sendFrame(40, 553, 1'b1, 1'b0, 1'b0);
    chk(lenOvf == 1'b1 && frameDone == 1'b0 && bitErr == 1'b0, "R9", "lenOvf", lenOvf, 1);
    chk(int'(bitCnt) == MAXB, "R9", "bitCnt at capacity", bitCnt, MAXB);
    chk(dataOut == expData, "R9", "first 552 bits kept", dataOut[63:0], expData[63:0]);

    // R10 line activity during transmit
    savedCnt = int'(bitCnt); savedErr = int'(preErrCnt);
    txActive = 1'b1; w(5);
    for (int i = 0; i < 30; i++) begin tog(); w(7 + (i % 5) * 11); end
    w(20); txActive = 1'b0; w(10);
    chk(int'(edgeCnt) == expEdges, "R10", "edgeCnt unchanged", edgeCnt, expEdges);
    chk(int'(bitCnt) == savedCnt && lenOvf == 1'b1 && int'(preErrCnt) == savedErr,
        "R10", "frame state unchanged", bitCnt, savedCnt);

    // R12 saturation of preamble errors
    ePer = 14'd64; tolWide = 1'b0;
    tog();
    for (int i = 0; i < 300; i++) begin w(20); tog(); end
    w(120);
    chk(preErrCnt == 8'hFF, "R12", "preErrCnt saturated", preErrCnt, 255);
    chk(int'(edgeCnt) == expEdges, "R11", "edgeCnt after burst", edgeCnt, expEdges);

    // R13 new preamble clears the previous frame, then random frames
    for (int f = 0; f < 6; f++) begin
      int per, n;
      per = int'($urandom_range(80, 20)) * 2;
      n   = int'($urandom_range(40, 1));
      for (int i = 0; i < n; i++) txBits[i] = $urandom_range(1, 0) == 1;
      if (f % 2 == 0) ePer = '0;
      else begin ePer = 14'(per); tolWide = $urandom_range(1, 0) == 1; end
      expLen = 10'(n); model(n);
      sendFrame(per, n, 1'b1, 1'b0, 1'b0);
      checkGood("R13", per);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule